// File: doc/BRIEF.md
# Flash Program/Erase Error Guard

This block watches the operating state of an on-chip flash array and decides, each cycle, which kinds of access are allowed: plain read, verify-read, program and erase. Software asks for program or erase mode through two enable bits. The block then watches the CPU side for events that must not occur while the array is being written. These events are a flash read, an exception, a sleep instruction and the loss of the bus.

If any of these events arrives during program or erase, the block raises a sticky error flag. It then moves to a protected mode in which reads still work but writing is locked out. It also sends a one-cycle pulse that initialises the control and block-select registers elsewhere in the chip. Software standby does not clear the flag, and no software action can clear it. Only the chip reset or the hardware-standby pin clears the flag, and both of these also return every register to its initial state.

The state is held in registers. The permission outputs are decoded from the registered state, so they follow a state change in the same cycle. The state code is driven out for use by neighbouring logic.

Top module: `flash_guard`

## Requirements
- R1: When `rst_i` is 1 or `hstby_n_i` is 0 at a clock edge, the state after that edge is hardware-protect (code 0). In that state every permission output is 0, `err_o` is 0 and `regs_clr_o` is 1. This takes priority over any event or standby strobe in the same cycle.
- R2: In hardware-protect, a clock edge with `rst_i` at 0 and `hstby_n_i` at 1 moves the state to normal (code 1). In normal, all four permissions are 1, and `err_o` and `regs_clr_o` are 0.
- R3: From normal, `prog_en_i`=1 moves the state to program (code 2), where only `prg_ok_o` is 1. `erase_en_i`=1 alone moves it to erase (code 3), where only `ers_ok_o` is 1. When both bits are 1, program wins.
- R4: In program or erase with both enable bits at 0, the state returns to normal.
- R5: In program or erase, a pulse on any of `ev_read_i`, `ev_exc_i`, `ev_sleep_i` or `ev_busloss_i` moves the state to error-protect (code 4). There `err_o` is 1, `rd_ok_o` and `vfy_ok_o` are 1, and `prg_ok_o` and `ers_ok_o` are 0.
- R6: `regs_clr_o` is 1 for exactly the first cycle of error-protect when that mode is entered from program or erase. It stays 0 when error-protect is re-entered from its standby variant.
- R7: In error-protect, the enable bits and the event inputs have no effect. The state and `err_o`=1 hold until R1 or R8 applies.
- R8: `sstby_enter_i` in error-protect moves the state to error-standby (code 6), where `err_o` stays 1 and all permissions are 0. `sstby_exit_i` there returns the state to error-protect.
- R9: `sstby_enter_i` in normal moves the state to standby (code 5), where `err_o` is 0 and all permissions are 0. The enable bits are ignored there. `sstby_exit_i` returns the state to normal.
- R10: Event pulses in normal have no effect on the state or on `err_o`.
- R11: `sstby_enter_i` in program or erase counts as an error event and leads to error-protect, as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high chip reset |
| hstby_n_i | input | 1 | Hardware standby request, active low |
| prog_en_i | input | 1 | Program enable bit |
| erase_en_i | input | 1 | Erase enable bit |
| sstby_enter_i | input | 1 | Software standby entry strobe |
| sstby_exit_i | input | 1 | Software standby release strobe |
| ev_read_i | input | 1 | CPU read of the flash (data, vector or fetch) |
| ev_exc_i | input | 1 | Non-reset exception taken |
| ev_sleep_i | input | 1 | Sleep instruction executed |
| ev_busloss_i | input | 1 | CPU lost the bus |
| err_o | output | 1 | Sticky error flag |
| rd_ok_o | output | 1 | Memory read allowed |
| vfy_ok_o | output | 1 | Verify-read allowed |
| prg_ok_o | output | 1 | Programming allowed |
| ers_ok_o | output | 1 | Erasing allowed |
| regs_clr_o | output | 1 | Initialise control and block-select registers |
| state_o | output | 3 | State code |

## Verification
The embedded properties check these rules on every cycle:
- the move to hardware-protect when standby is asserted;
- the move to error-protect when an event is seen while writing;
- the flag staying set while the standby pin is high;
- events in normal being ignored;
- the clear pulse lasting one cycle;
- no write permission ever appearing alongside the error flag.

Only the bench's scenarios can show the following:
- priority between simultaneous reset and event inputs;
- the round trips through both standby variants, including the absence of a clear pulse on return from error-standby;
- the exact permission pattern of each state against the requirement table.

// File: rtl/flpe_pkg.sv
package flpe_pkg;

    localparam int ST_W  = 3;
    localparam int EVT_W = 4;

    typedef enum logic [ST_W-1:0] {
        ST_HWPROT  = 3'd0,
        ST_NORMAL  = 3'd1,
        ST_PROG    = 3'd2,
        ST_ERASE   = 3'd3,
        ST_ERRPROT = 3'd4,
        ST_SSTBY   = 3'd5,
        ST_ERRSTBY = 3'd6
    } guard_state_e;

    typedef struct packed {
        logic rd;
        logic vfy;
        logic prg;
        logic ers;
    } access_t;

    typedef struct packed {
        logic prog;
        logic erase;
        logic stby_enter;
        logic stby_exit;
    } ctrl_t;

    function automatic logic is_writing(guard_state_e s);
        return (s == ST_PROG) || (s == ST_ERASE);
    endfunction

    function automatic logic is_err(guard_state_e s);
        return (s == ST_ERRPROT) || (s == ST_ERRSTBY);
    endfunction

    function automatic access_t access_of(guard_state_e s);
        access_t a;
        a = '0;
        case (s)
            ST_NORMAL:  a = '{rd: 1'b1, vfy: 1'b1, prg: 1'b1, ers: 1'b1};
            ST_PROG:    a = '{rd: 1'b0, vfy: 1'b0, prg: 1'b1, ers: 1'b0};
            ST_ERASE:   a = '{rd: 1'b0, vfy: 1'b0, prg: 1'b0, ers: 1'b1};
            ST_ERRPROT: a = '{rd: 1'b1, vfy: 1'b1, prg: 1'b0, ers: 1'b0};
            default:    a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/flpe_event_merge.sv
module flpe_event_merge #(
    parameter int                      EVT_W  = flpe_pkg::EVT_W,
    parameter logic [EVT_W-1:0]        EVT_EN = '1
) (
    input  logic [EVT_W-1:0] evt_i,
    input  logic             armed_i,
    output logic             hit_o
);
    logic [EVT_W-1:0] gated;

    for (genvar g = 0; g < EVT_W; g++) begin : g_evt
        if (EVT_EN[g]) begin : g_on
            assign gated[g] = evt_i[g] & armed_i;
        end else begin : g_off
            assign gated[g] = 1'b0;
        end
    end

    assign hit_o = |gated;

    always_comb begin
        // R10
        evt_unarmed_chk: assert (armed_i || !hit_o);
    end
endmodule

// File: rtl/flpe_state_ctrl.sv
module flpe_state_ctrl
    import flpe_pkg::*;
(
    input  logic         clk,
    input  logic         rst_i,
    input  logic         hstby_n_i,
    input  ctrl_t        ctrl_i,
    input  logic         evt_hit_i,
    output guard_state_e state_o,
    output logic         clr_o
);
    guard_state_e state_q, state_d;
    logic         clr_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_HWPROT: state_d = ST_NORMAL;
            ST_NORMAL: begin
                if (ctrl_i.stby_enter)  state_d = ST_SSTBY;
                else if (ctrl_i.prog)   state_d = ST_PROG;
                else if (ctrl_i.erase)  state_d = ST_ERASE;
            end
            ST_PROG: begin
                if (evt_hit_i || ctrl_i.stby_enter) state_d = ST_ERRPROT;
                else if (!ctrl_i.prog)
                    state_d = ctrl_i.erase ? ST_ERASE : ST_NORMAL;
            end
            ST_ERASE: begin
                if (evt_hit_i || ctrl_i.stby_enter) state_d = ST_ERRPROT;
                else if (!ctrl_i.erase)
                    state_d = ctrl_i.prog ? ST_PROG : ST_NORMAL;
            end
            ST_ERRPROT: if (ctrl_i.stby_enter) state_d = ST_ERRSTBY;
            ST_SSTBY:   if (ctrl_i.stby_exit)  state_d = ST_NORMAL;
            ST_ERRSTBY: if (ctrl_i.stby_exit)  state_d = ST_ERRPROT;
            default:    state_d = ST_HWPROT;
        endcase
        if (!hstby_n_i) state_d = ST_HWPROT;
    end

    always_ff @(posedge clk) begin
        if (rst_i) begin
            state_q <= ST_HWPROT;
            clr_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            clr_q   <= (state_d == ST_HWPROT) ||
                       ((state_d == ST_ERRPROT) && is_writing(state_q));
        end
    end

    assign state_o = state_q;
    assign clr_o   = clr_q;

    // R1
    hwstby_prot_chk: assert property (@(posedge clk) disable iff (rst_i)
        !hstby_n_i |=> (state_q == ST_HWPROT));

    // R5
    evt_err_chk: assert property (@(posedge clk) disable iff (rst_i)
        (is_writing(state_q) && evt_hit_i && hstby_n_i) |=> (state_q == ST_ERRPROT));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst_i)
        (is_err(state_q) && hstby_n_i) |=> is_err(state_q));

    // R10
    normal_quiet_chk: assert property (@(posedge clk) disable iff (rst_i)
        (state_q == ST_NORMAL && hstby_n_i && !ctrl_i.prog && !ctrl_i.erase
         && !ctrl_i.stby_enter) |=> (state_q == ST_NORMAL));

    // R6
    clr_single_chk: assert property (@(posedge clk) disable iff (rst_i)
        (clr_q && state_q == ST_ERRPROT) |=> (!clr_q || state_q == ST_HWPROT));

    // R6
    clr_on_err_chk: assert property (@(posedge clk) disable iff (rst_i)
        (is_writing(state_q) && state_d == ST_ERRPROT) |=> clr_q);
endmodule

// File: rtl/flpe_access_decode.sv
module flpe_access_decode
    import flpe_pkg::*;
(
    input  guard_state_e state_i,
    output access_t      acc_o,
    output logic         err_o
);
    assign acc_o = access_of(state_i);
    assign err_o = is_err(state_i);

    always_comb begin
        // R5
        err_nowrite_chk: assert (!(err_o && (acc_o.prg || acc_o.ers)));
    end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flpe_pkg::*;
#(
    parameter logic [EVT_W-1:0] EVT_EN = '1
) (
    input  logic            clk,
    input  logic            rst_i,
    input  logic            hstby_n_i,
    input  logic            prog_en_i,
    input  logic            erase_en_i,
    input  logic            sstby_enter_i,
    input  logic            sstby_exit_i,
    input  logic            ev_read_i,
    input  logic            ev_exc_i,
    input  logic            ev_sleep_i,
    input  logic            ev_busloss_i,
    output logic            err_o,
    output logic            rd_ok_o,
    output logic            vfy_ok_o,
    output logic            prg_ok_o,
    output logic            ers_ok_o,
    output logic            regs_clr_o,
    output logic [ST_W-1:0] state_o
);
    guard_state_e     state;
    ctrl_t            ctrl;
    access_t          acc;
    logic [EVT_W-1:0] evt;
    logic             evt_hit;

    assign ctrl = '{prog: prog_en_i, erase: erase_en_i,
                    stby_enter: sstby_enter_i, stby_exit: sstby_exit_i};
    assign evt  = {ev_busloss_i, ev_sleep_i, ev_exc_i, ev_read_i};

    flpe_event_merge #(.EVT_W(EVT_W), .EVT_EN(EVT_EN)) u_evt (
        .evt_i   (evt),
        .armed_i (is_writing(state)),
        .hit_o   (evt_hit)
    );

    flpe_state_ctrl u_ctrl (
        .clk       (clk),
        .rst_i     (rst_i),
        .hstby_n_i (hstby_n_i),
        .ctrl_i    (ctrl),
        .evt_hit_i (evt_hit),
        .state_o   (state),
        .clr_o     (regs_clr_o)
    );

    flpe_access_decode u_dec (
        .state_i (state),
        .acc_o   (acc),
        .err_o   (err_o)
    );

    assign rd_ok_o  = acc.rd;
    assign vfy_ok_o = acc.vfy;
    assign prg_ok_o = acc.prg;
    assign ers_ok_o = acc.ers;
    assign state_o  = state;
endmodule

// File: tb/test_flash_guard.sv
module test_flash_guard;
    logic clk = 1'b0;
    logic rst_i = 1'b1, hstby_n_i = 1'b1, prog_en_i = 1'b0, erase_en_i = 1'b0;
    logic sstby_enter_i = 1'b0, sstby_exit_i = 1'b0;
    logic ev_read_i = 1'b0, ev_exc_i = 1'b0, ev_sleep_i = 1'b0, ev_busloss_i = 1'b0;
    logic err_o, rd_ok_o, vfy_ok_o, prg_ok_o, ers_ok_o, regs_clr_o;
    logic [2:0] state_o;

    always #5 clk = ~clk;

    flash_guard i_flash_guard (.*);

    typedef struct {
        int    st;
        bit    err;
        bit    clr;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0, failures = 0;
    bit done = 1'b0;

    function automatic logic [3:0] perms_for(int st);
        case (st)
            1: return 4'b1111;
            2: return 4'b0010;
            3: return 4'b0001;
            4: return 4'b1100;
            default: return 4'b0000;
        endcase
    endfunction

    // Driver: ev = {busloss, sleep, exception, read}
    task automatic step(input bit r, input bit hs_n, input bit p, input bit e,
                        input bit se, input bit sx, input logic [3:0] ev,
                        input int st, input bit err, input bit clr, input string req);
        exp_t it;
        @(negedge clk);
        rst_i = r; hstby_n_i = hs_n; prog_en_i = p; erase_en_i = e;
        sstby_enter_i = se; sstby_exit_i = sx;
        {ev_busloss_i, ev_sleep_i, ev_exc_i, ev_read_i} = ev;
        it.st = st; it.err = err; it.clr = clr; it.req = req;
        exp_q.push_back(it);
    endtask

    // Monitor
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t it;
            logic [3:0] ep, ap;
            it = exp_q.pop_front();
            ep = perms_for(it.st);
            ap = {rd_ok_o, vfy_ok_o, prg_ok_o, ers_ok_o};
            checks++;
            if (int'(state_o) != it.st || err_o != it.err || regs_clr_o != it.clr || ap != ep) begin
                failures++;
                $display("FAIL %s: state=%0d err=%0b clr=%0b perms=%b expected state=%0d err=%0b clr=%0b perms=%b",
                         it.req, state_o, err_o, regs_clr_o, ap, it.st, it.err, it.clr, ep);
            end
        end
    end

    initial begin
        step(1,1,0,0,0,0,4'b0000, 0,0,1, "R1 reset");
        step(0,1,0,0,0,0,4'b0000, 1,0,0, "R2 release");
        step(0,1,0,0,0,0,4'b1111, 1,0,0, "R10 events in normal");
        step(0,1,1,0,0,0,4'b0000, 2,0,0, "R3 program");
        step(0,1,1,0,0,0,4'b0000, 2,0,0, "R3 hold program");
        step(0,1,0,0,0,0,4'b0000, 1,0,0, "R4 program end");
        step(0,1,0,1,0,0,4'b0000, 3,0,0, "R3 erase");
        step(0,1,0,0,0,0,4'b0000, 1,0,0, "R4 erase end");
        step(0,1,1,1,0,0,4'b0000, 2,0,0, "R3 both bits");
        step(0,1,1,1,0,0,4'b0001, 4,1,1, "R5 R6 read event");
        step(0,1,1,1,0,0,4'b0010, 4,1,0, "R7 R6 event ignored");
        step(0,1,0,0,0,0,4'b0000, 4,1,0, "R7 bits cleared");
        step(0,1,0,0,1,0,4'b0000, 6,1,0, "R8 error standby");
        step(0,1,1,0,0,0,4'b0000, 6,1,0, "R8 hold");
        step(0,1,0,0,0,1,4'b0000, 4,1,0, "R8 exit no clear");
        step(0,0,0,0,0,0,4'b0000, 0,0,1, "R1 hw standby");
        step(0,0,1,0,0,0,4'b0000, 0,0,1, "R1 hw standby held");
        step(0,1,0,0,0,0,4'b0000, 1,0,0, "R2 hw standby release");
        step(0,1,0,0,1,0,4'b0000, 5,0,0, "R9 standby");
        step(0,1,1,0,0,0,4'b0001, 5,0,0, "R9 bits ignored");
        step(0,1,0,0,0,1,4'b0000, 1,0,0, "R9 exit");
        step(0,1,0,1,0,0,4'b0000, 3,0,0, "R3 erase again");
        step(0,1,0,1,0,0,4'b1000, 4,1,1, "R5 bus loss");
        step(1,1,0,0,0,0,4'b0100, 0,0,1, "R1 reset clears flag");
        step(0,1,0,0,0,0,4'b0000, 1,0,0, "R2 release");
        step(0,1,0,1,0,0,4'b0000, 3,0,0, "R3 erase");
        step(0,1,0,1,0,0,4'b0100, 4,1,1, "R5 sleep");
        step(1,1,0,0,0,0,4'b0000, 0,0,1, "R1 reset");
        step(0,1,0,0,0,0,4'b0000, 1,0,0, "R2 release");
        step(0,1,1,0,0,0,4'b0000, 2,0,0, "R3 program");
        step(0,1,1,0,1,0,4'b0000, 4,1,1, "R11 standby in program");
        step(1,1,0,0,0,0,4'b0000, 0,0,1, "R1 reset");
        step(0,1,0,0,0,0,4'b0000, 1,0,0, "R2 release");
        step(0,1,1,0,0,0,4'b0000, 2,0,0, "R3 program");
        step(0,0,1,0,0,0,4'b0010, 0,0,1, "R1 priority over exception");
        step(0,1,0,0,0,0,4'b0000, 1,0,0, "R2 release");
        step(0,1,0,1,0,0,4'b0000, 3,0,0, "R3 erase");
        step(0,1,0,1,0,0,4'b0010, 4,1,1, "R5 exception");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule